// File: doc/BRIEF.md
# Register Transfer Bus for an Accumulator Machine

This block is the shared 16-bit transfer path between the registers of a small accumulator machine. A 3-bit select code picks exactly one source to place on the bus. Any number of destination registers may capture the bus value on the same rising clock edge. The sources are the address register, the program counter, the data register, the accumulator (supplied from outside), the instruction register, the scratch register, memory read data and an 8-bit input character.

The block holds the address register (12 bits), the program counter (12 bits), the data register, the instruction register, the scratch register (16 bits each) and the 8-bit output character register. The address, program-counter, data and scratch registers can also be incremented and cleared. The instruction and output registers can only be loaded.

Because the registers differ in width, the bus applies fixed rules. Narrow sources are zero-extended when they drive the bus. Narrow destinations keep only the low bits of the bus. The memory port always takes its address from the address register, and its write data is the bus. The accumulator datapath, the instruction decoding and the memory array lie outside the block.

Top module: `xfer_bus_core`

## Requirements
- R1: While `rst` is high at a rising edge, every held register (address, program counter, data, instruction, scratch, output character) becomes zero.
- R2: Select codes 1 to 6 drive the bus with, in that order: address register, program counter, data register, `acc_in`, instruction register, scratch register. The 12-bit address and program-counter values appear on bus bits 11:0, and bus bits 15:12 are zero.
- R3: Select code 7 drives `mem_rdata` onto the bus only while `mem_rd` is high. With code 7 and `mem_rd` low, the bus is all zero.
- R4: Select code 0 drives zero. When `inchar_en` is also high, it drives `in_char` on bus bits 7:0 with bits 15:8 zero. `inchar_en` has no effect under any other select code.
- R5: A register whose load input is high takes the bus value at the next rising edge. The address register and program counter capture only bus bits 11:0.
- R6: The output character register loads bus bits 7:0 when `outr_ld` is high, and holds its value otherwise. No select code places it on the bus.
- R7: An increment on the address register, program counter, data register or scratch register adds one at the next edge, wrapping from all-ones to zero.
- R8: A clear on the address register, program counter, data register or scratch register sets it to zero at the next edge.
- R9: When controls coincide on one register, clear beats load and load beats increment.
- R10: `mem_addr` always equals the address register, `mem_wdata` always equals the bus, and `mem_we` follows `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source select code |
| acc_in | input | 16 | Accumulator value offered as a bus source |
| in_char | input | 8 | Input character value |
| inchar_en | input | 1 | Places `in_char` on the bus under select code 0 |
| mem_rd | input | 1 | Memory read enable, gates select code 7 |
| mem_wr | input | 1 | Memory write request |
| mem_rdata | input | 16 | Memory read data |
| ar_ld | input | 1 | Address register load |
| ar_inc | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load |
| dr_inc | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| tr_ld | input | 1 | Scratch register load |
| tr_inc | input | 1 | Scratch register increment |
| tr_clr | input | 1 | Scratch register clear |
| ir_ld | input | 1 | Instruction register load |
| outr_ld | input | 1 | Output character register load |
| bus_out | output | 16 | Current bus value |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (bus) |
| mem_we | output | 1 | Memory write enable |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Scratch register |
| outr_q | output | 8 | Output character register |

## Verification
The transfers use values with distinct upper and lower bytes and distinct upper nibbles, such as A5C3, FFFF, 1234 and BEEF. This lets a missing zero-extension, a truncation that keeps the wrong bits, or a swapped select code show up as a wrong bus or register value. Memory read data is tried with the read enable both high and low. The input character is tried under code 0, with its enable on and off, and under a nonzero code. Increments start from all-ones to expose a wrong wrap. Clear, load and increment are applied in combinations on one register, which tells the priority order apart. A write to the bench memory followed by a read-back of the same address ties the address, write-data and write-enable outputs together.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;
endpackage

// File: rtl/xbus_reg.sv
// One bus-attached register. Clear beats load, and load beats increment.
// HAS_INC = 0 builds a load-only register.
module xbus_reg #(
  parameter int W       = 16,
  parameter bit HAS_INC = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (HAS_INC) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (ld)    q <= d;
        else if (inc)   q <= q + 1'b1;
      end
    end else begin : g_ld
      logic unused_inc;
      assign unused_inc = inc;
      always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (ld)    q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/xbus_srcmux.sv
// Bus source selection, including the zero-extension of narrow sources.
module xbus_srcmux
  import xbus_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  bus_src_e      sel,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] dr,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] tr,
  input  logic [DW-1:0] mrd,
  input  logic          mem_rd,
  input  logic [CW-1:0] in_char,
  input  logic          inchar_en,
  output logic [DW-1:0] bus
);
  localparam int APAD = DW - AW;
  localparam int CPAD = DW - CW;

  always_comb begin
    bus = '0;
    unique case (sel)
      SRC_NONE: if (inchar_en) bus = {{CPAD{1'b0}}, in_char};
      SRC_AR:   bus = {{APAD{1'b0}}, ar};
      SRC_PC:   bus = {{APAD{1'b0}}, pc};
      SRC_DR:   bus = dr;
      SRC_AC:   bus = ac;
      SRC_IR:   bus = ir;
      SRC_TR:   bus = tr;
      SRC_MEM:  if (mem_rd) bus = mrd;
      default:  bus = '0;
    endcase
  end
endmodule

// File: rtl/xfer_bus_core.sv
module xfer_bus_core
  import xbus_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] bus_sel,
  input  logic [DW-1:0]   acc_in,
  input  logic [CW-1:0]   in_char,
  input  logic            inchar_en,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            ar_ld,
  input  logic            ar_inc,
  input  logic            ar_clr,
  input  logic            pc_ld,
  input  logic            pc_inc,
  input  logic            pc_clr,
  input  logic            dr_ld,
  input  logic            dr_inc,
  input  logic            dr_clr,
  input  logic            tr_ld,
  input  logic            tr_inc,
  input  logic            tr_clr,
  input  logic            ir_ld,
  input  logic            outr_ld,
  output logic [DW-1:0]   bus_out,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic [AW-1:0]   ar_q,
  output logic [AW-1:0]   pc_q,
  output logic [DW-1:0]   dr_q,
  output logic [DW-1:0]   ir_q,
  output logic [DW-1:0]   tr_q,
  output logic [CW-1:0]   outr_q
);
  logic [DW-1:0] bus_w;
  bus_src_e      sel_e;

  assign sel_e = bus_src_e'(bus_sel);

  xbus_srcmux #(.AW(AW), .DW(DW), .CW(CW)) u_mux (
    .sel(sel_e), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(acc_in),
    .ir(ir_q), .tr(tr_q), .mrd(mem_rdata), .mem_rd(mem_rd),
    .in_char(in_char), .inchar_en(inchar_en), .bus(bus_w)
  );

  xbus_reg #(.W(AW), .HAS_INC(1'b1)) u_ar (
    .clk(clk), .rst(rst), .clr(ar_clr), .ld(ar_ld), .inc(ar_inc),
    .d(bus_w[AW-1:0]), .q(ar_q)
  );
  xbus_reg #(.W(AW), .HAS_INC(1'b1)) u_pc (
    .clk(clk), .rst(rst), .clr(pc_clr), .ld(pc_ld), .inc(pc_inc),
    .d(bus_w[AW-1:0]), .q(pc_q)
  );
  xbus_reg #(.W(DW), .HAS_INC(1'b1)) u_dr (
    .clk(clk), .rst(rst), .clr(dr_clr), .ld(dr_ld), .inc(dr_inc),
    .d(bus_w), .q(dr_q)
  );
  xbus_reg #(.W(DW), .HAS_INC(1'b1)) u_tr (
    .clk(clk), .rst(rst), .clr(tr_clr), .ld(tr_ld), .inc(tr_inc),
    .d(bus_w), .q(tr_q)
  );
  xbus_reg #(.W(DW), .HAS_INC(1'b0)) u_ir (
    .clk(clk), .rst(rst), .clr(1'b0), .ld(ir_ld), .inc(1'b0),
    .d(bus_w), .q(ir_q)
  );
  xbus_reg #(.W(CW), .HAS_INC(1'b0)) u_outr (
    .clk(clk), .rst(rst), .clr(1'b0), .ld(outr_ld), .inc(1'b0),
    .d(bus_w[CW-1:0]), .q(outr_q)
  );

  assign bus_out   = bus_w;
  assign mem_addr  = ar_q;
  assign mem_wdata = bus_w;
  assign mem_we    = mem_wr;
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    bus_sel,
  input logic          mem_rd,
  input logic [DW-1:0] bus_out,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] ar_q,
  input logic [AW-1:0] pc_q,
  input logic [CW-1:0] outr_q,
  input logic          ar_ld,
  input logic          ar_clr,
  input logic          pc_ld,
  input logic          pc_inc,
  input logic          pc_clr,
  input logic          outr_ld
);
  a_r2_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> bus_out[DW-1:AW] == '0);

  a_r3_mem_gate: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 3'd7 && !mem_rd) |-> bus_out == '0);

  a_r5_ar_load: assert property (@(posedge clk) disable iff (rst)
    (ar_ld && !ar_clr) |=> ar_q == $past(bus_out[AW-1:0]));

  a_r6_outr_hold: assert property (@(posedge clk) disable iff (rst)
    !outr_ld |=> $stable(outr_q));

  a_r7_pc_inc: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_ld && !pc_clr) |=> pc_q == $past(pc_q) + 1'b1);

  a_r8_ar_clear: assert property (@(posedge clk) disable iff (rst)
    ar_clr |=> ar_q == '0);

  a_r10_addr: assert property (@(posedge clk) disable iff (rst)
    mem_addr == ar_q);
endmodule

bind xfer_bus_core xbus_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .mem_rd(mem_rd),
  .bus_out(bus_out), .mem_addr(mem_addr), .ar_q(ar_q), .pc_q(pc_q),
  .outr_q(outr_q), .ar_ld(ar_ld), .ar_clr(ar_clr), .pc_ld(pc_ld),
  .pc_inc(pc_inc), .pc_clr(pc_clr), .outr_ld(outr_ld)
);

// File: tb/sim_xfer_bus_core.sv
`timescale 1ns/1ps
module sim_xfer_bus_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_sel = '0;
  logic [15:0] acc_in = '0;
  logic [7:0] in_char = '0;
  logic inchar_en = 0, mem_rd = 0, mem_wr = 0;
  logic [15:0] mem_rdata;
  logic ar_ld = 0, ar_inc = 0, ar_clr = 0, pc_ld = 0, pc_inc = 0, pc_clr = 0;
  logic dr_ld = 0, dr_inc = 0, dr_clr = 0, tr_ld = 0, tr_inc = 0, tr_clr = 0;
  logic ir_ld = 0, outr_ld = 0;
  logic [15:0] bus_out, mem_wdata, dr_q, ir_q, tr_q;
  logic [11:0] mem_addr, ar_q, pc_q;
  logic [7:0] outr_q;
  logic mem_we;
  logic [15:0] mem [16];
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[3:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;

  xfer_bus_core u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .acc_in(acc_in), .in_char(in_char),
    .inchar_en(inchar_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr), .pc_ld(pc_ld), .pc_inc(pc_inc),
    .pc_clr(pc_clr), .dr_ld(dr_ld), .dr_inc(dr_inc), .dr_clr(dr_clr), .tr_ld(tr_ld),
    .tr_inc(tr_inc), .tr_clr(tr_clr), .ir_ld(ir_ld), .outr_ld(outr_ld),
    .bus_out(bus_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ir_q(ir_q), .tr_q(tr_q), .outr_q(outr_q)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 0; inchar_en = 0; mem_rd = 0; mem_wr = 0;
    ar_ld = 0; ar_inc = 0; ar_clr = 0; pc_ld = 0; pc_inc = 0; pc_clr = 0;
    dr_ld = 0; dr_inc = 0; dr_clr = 0; tr_ld = 0; tr_inc = 0; tr_clr = 0;
    ir_ld = 0; outr_ld = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
    #0.5;
  endtask

  task automatic t_reset();
    chk("R1 ar", {4'h0, ar_q}, 16'h0);
    chk("R1 pc", {4'h0, pc_q}, 16'h0);
    chk("R1 dr", dr_q, 16'h0);
    chk("R1 ir", ir_q, 16'h0);
    chk("R1 tr", tr_q, 16'h0);
    chk("R1 outr", {8'h0, outr_q}, 16'h0);
  endtask

  task automatic t_mem_source();
    bus_sel = 3'd7; mem_rd = 1; dr_ld = 1; #0.5;
    chk("R3 mem read on bus", bus_out, 16'hA5C3);
    tick();
    chk("R5 dr load", dr_q, 16'hA5C3);
    bus_sel = 3'd7; mem_rd = 0; #0.5;
    chk("R3 mem gated off", bus_out, 16'h0000);
    idle();
  endtask

  task automatic t_truncate_extend();
    bus_sel = 3'd3; ar_ld = 1; #0.5;
    chk("R2 dr source", bus_out, 16'hA5C3);
    tick();
    chk("R5 ar truncation", {4'h0, ar_q}, 16'h05C3);
    bus_sel = 3'd1; #0.5;
    chk("R2 ar zero-extend", bus_out, 16'h05C3);
    chk("R10 addr", {4'h0, mem_addr}, 16'h05C3);
    idle();
    acc_in = 16'hFFFF; bus_sel = 3'd4; pc_ld = 1; #0.5;
    chk("R2 ac source", bus_out, 16'hFFFF);
    tick();
    chk("R5 pc truncation", {4'h0, pc_q}, 16'h0FFF);
    bus_sel = 3'd2; #0.5;
    chk("R2 pc zero-extend", bus_out, 16'h0FFF);
    idle();
  endtask

  task automatic t_ir_tr();
    acc_in = 16'h1234; bus_sel = 3'd4; ir_ld = 1; tick();
    chk("R5 ir load", ir_q, 16'h1234);
    bus_sel = 3'd5; tr_ld = 1; #0.5;
    chk("R2 ir source", bus_out, 16'h1234);
    tick();
    chk("R5 tr load", tr_q, 16'h1234);
    bus_sel = 3'd6; #0.5;
    chk("R2 tr source", bus_out, 16'h1234);
    idle();
  endtask

  task automatic t_inchar();
    in_char = 8'h7E; inchar_en = 1; bus_sel = 3'd0; #0.5;
    chk("R4 inchar on bus", bus_out, 16'h007E);
    inchar_en = 0; #0.5;
    chk("R4 code 0 zero", bus_out, 16'h0000);
    inchar_en = 1; bus_sel = 3'd3; #0.5;
    chk("R4 inchar ignored", bus_out, 16'hA5C3);
    idle();
  endtask

  task automatic t_outr();
    bus_sel = 3'd3; outr_ld = 1; tick();
    chk("R6 outr low byte", {8'h0, outr_q}, 16'h00C3);
    acc_in = 16'h0055; bus_sel = 3'd4; tick();
    chk("R6 outr holds", {8'h0, outr_q}, 16'h00C3);
  endtask

  task automatic t_inc_clr();
    pc_inc = 1; dr_inc = 1; tr_inc = 1; ar_inc = 1; tick();
    chk("R7 pc wrap", {4'h0, pc_q}, 16'h0000);
    chk("R7 dr inc", dr_q, 16'hA5C4);
    chk("R7 tr inc", tr_q, 16'h1235);
    chk("R7 ar inc", {4'h0, ar_q}, 16'h05C4);
    ar_clr = 1; dr_clr = 1; tr_clr = 1; tick();
    chk("R8 ar clr", {4'h0, ar_q}, 16'h0);
    chk("R8 dr clr", dr_q, 16'h0);
    chk("R8 tr clr", tr_q, 16'h0);
    acc_in = 16'h0123; bus_sel = 3'd4; pc_ld = 1; tick();
    pc_clr = 1; tick();
    chk("R8 pc clr", {4'h0, pc_q}, 16'h0);
  endtask

  task automatic t_priority();
    acc_in = 16'h0ABC; bus_sel = 3'd4; ar_ld = 1; tick();
    acc_in = 16'h0321; bus_sel = 3'd4; ar_clr = 1; ar_ld = 1; ar_inc = 1; tick();
    chk("R9 clr over ld/inc", {4'h0, ar_q}, 16'h0);
    acc_in = 16'h0321; bus_sel = 3'd4; ar_ld = 1; ar_inc = 1; tick();
    chk("R9 ld over inc", {4'h0, ar_q}, 16'h0321);
    acc_in = 16'h7777; bus_sel = 3'd4; dr_clr = 1; dr_inc = 1; tick();
    chk("R9 clr over inc", dr_q, 16'h0);
  endtask

  task automatic t_mem_write();
    acc_in = 16'h0005; bus_sel = 3'd4; ar_ld = 1; tick();
    acc_in = 16'hBEEF; bus_sel = 3'd4; mem_wr = 1; #0.5;
    chk("R10 wdata", mem_wdata, 16'hBEEF);
    chk("R10 we", {15'h0, mem_we}, 16'h1);
    tick();
    chk("R10 we low", {15'h0, mem_we}, 16'h0);
    bus_sel = 3'd7; mem_rd = 1; #0.5;
    chk("R10 readback", bus_out, 16'hBEEF);
    idle();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h1111 * i[15:0];
    mem[0] = 16'hA5C3;
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0; #0.5;
    t_reset();
    t_mem_source();
    t_truncate_extend();
    t_ir_tr();
    t_inchar();
    t_outr();
    t_inc_clr();
    t_priority();
    t_mem_write();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule